// File: doc/BRIEF.md
# Up-counting timer with preload and active register pairs

This block is a general-purpose up-counter driven through a small word-addressed register interface. Software sets three values: a clock divider, a wrap limit and a compare threshold. Each value is written into a preload register that the counting logic never looks at. A hidden active copy of each value does the real work. The active copies take on the preload contents only at an update event. A value written in the middle of a counting cycle therefore cannot cut that cycle short or stretch it: it applies from the next cycle on.

An update event happens in two ways. The counter can pass its active limit on a divided tick and roll back to zero, or software can request one through the control register. Each update event produces a one-clock pulse on `upd_o`, meant to drive an interrupt line or a DMA request. A second output, `cmp_o`, reports whether the counter has reached the active compare threshold.

A typical use is as follows. Program the three preload registers, then write the control register with both the enable bit and the force-update bit set. This loads every active copy and starts counting from zero. After that, new values can be written at any time and take effect at the next rollover.

Top module: `shadow_timer`

## Requirements
- R1: After reset, every register reads zero, the counter holds at zero, `upd_o` is low, and `cmp_o` is high because 0 >= 0.
- R2: While enabled, the counter advances once every P+1 clock cycles, where P is the active divider value.
- R3: When a divided tick finds the counter equal to the active limit A, the counter returns to zero on that tick. The counter therefore never exceeds A.
- R4: Every update event raises `upd_o` for exactly one clock, in the cycle that follows the clock edge of the event.
- R5: Writes to the divider, limit and compare preloads leave the active copies unchanged until the next update event. At that event all three active copies are loaded together.
- R6: When a preload write and an update event fall on the same clock edge, the active copy receives the value that was in the preload before the write. The new value waits for the next update event.
- R7: Writing 1 to control bit 1 (offset 0x0) is a forced update. It clears the counter and the divider count, loads all active copies and pulses `upd_o`, and it does so even while the timer is disabled. Bit 1 always reads back 0.
- R8: Control bit 0 is the enable bit. While it is 0, the counter and the divider count hold their values and no rollover occurs.
- R9: `cmp_o` is high exactly when the counter is greater than or equal to the active compare value.
- R10: The register offsets are: 0x0 control, 0x4 divider preload, 0x8 limit preload, 0xC compare preload, and 0x10 counter, which is read-only and ignores writes. Reading a preload offset returns the preload value, not the active value. Any other address, including one that is not word-aligned, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe; the write occurs on the clock edge |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the address |
| upd_o | output | 1 | One-clock update-event pulse |
| cmp_o | output | 1 | High while counter >= active compare |

## Verification
A software write to a preload register and a natural rollover can land on the same clock edge. That is the race the preload/active split exists to settle. The bench counts edges from a forced update so that it can place a write to the limit preload exactly on the rollover edge. It then checks that the counter keeps the old limit for one more full cycle and changes to the new limit only at the rollover after that. The bench also issues a forced update while the timer is disabled and checks that the counter clears and the pulse still appears.

// File: rtl/shtmr_pkg.sv
package shtmr_pkg;

   // Word index of each register (byte offset divided by four)
   typedef enum logic [2:0] {
      IDX_CTRL = 3'd0,
      IDX_DIV  = 3'd1,
      IDX_LIM  = 3'd2,
      IDX_CMP  = 3'd3,
      IDX_CNT  = 3'd4
   } reg_idx_e;

   localparam int CTRL_RUN_BIT   = 0;
   localparam int CTRL_FORCE_BIT = 1;
   localparam int MAP_ADDR_BITS  = 5;

endpackage

// File: rtl/shtmr_shadow.sv
// One preload/active register pair. The load takes the preload value as it
// stood before this edge, so a same-edge write waits for the next load.
module shtmr_shadow #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic         load_i,
   output logic [W-1:0] pre_o,
   output logic [W-1:0] act_o
);

   if (W < 1) begin : g_bad_width
      $error("shtmr_shadow: W must be at least 1");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_o <= '0;
         act_o <= '0;
      end else begin
         if (wr_i)   pre_o <= wdata_i;
         if (load_i) act_o <= pre_o;
      end
   end

   // R5
   act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(act_o));

   // R6
   load_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && wr_i) |=> (act_o == $past(pre_o)));

endmodule

// File: rtl/shtmr_divider.sv
// Clock divider: one tick every (limit+1) enabled cycles.
module shtmr_divider #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         run_i,
   input  logic         clr_i,
   input  logic [W-1:0] limit_i,
   output logic         tick_o
);

   logic [W-1:0] div_q;

   assign tick_o = run_i && !clr_i && (div_q == limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      div_q <= '0;
      else if (clr_i)   div_q <= '0;
      else if (tick_o)  div_q <= '0;
      else if (run_i)   div_q <= div_q + 1'b1;
   end

   // R8
   div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !clr_i) |=> $stable(div_q));

   // R7
   div_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (div_q == '0));

endmodule

// File: rtl/shtmr_counter.sv
// Main up-counter with rollover at the active limit.
module shtmr_counter #(
   parameter int W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         tick_i,
   input  logic         clr_i,
   input  logic [W-1:0] limit_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);

   assign wrap_o = tick_i && (cnt_o == limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_o <= '0;
      else if (clr_i)   cnt_o <= '0;
      else if (wrap_o)  cnt_o <= '0;
      else if (tick_i)  cnt_o <= cnt_o + 1'b1;
   end

   // R3
   wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> (cnt_o == '0));

   // R2
   step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !wrap_o && !clr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/shadow_timer.sv
module shadow_timer
   import shtmr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int DIV_W  = 16,
   parameter int ADDR_W = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              upd_o,
   output logic              cmp_o
);

   if (CNT_W > DATA_W || DIV_W > DATA_W) begin : g_bad_fit
      $error("shadow_timer: CNT_W and DIV_W must fit in DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("shadow_timer: DATA_W must hold the control bits");
   end
   if (ADDR_W < MAP_ADDR_BITS) begin : g_bad_addr
      $error("shadow_timer: ADDR_W too small for the register map");
   end

   // ---------------- address decode ----------------
   reg_idx_e   idx;
   logic       in_map;
   logic       wr_any;
   logic       wr_ctrl, wr_div, wr_lim, wr_cmp;
   logic       unused_wdata;

   assign idx    = reg_idx_e'(bus_addr_i[4:2]);
   assign in_map = ((bus_addr_i >> MAP_ADDR_BITS) == '0) && (bus_addr_i[1:0] == 2'b00);
   assign wr_any = bus_sel_i && bus_wr_i && in_map;
   assign wr_ctrl = wr_any && (idx == IDX_CTRL);
   assign wr_div  = wr_any && (idx == IDX_DIV);
   assign wr_lim  = wr_any && (idx == IDX_LIM);
   assign wr_cmp  = wr_any && (idx == IDX_CMP);
   assign unused_wdata = ^bus_wdata_i;

   // ---------------- control ----------------
   logic run_q;
   logic force_upd;
   logic tick, wrap, uev;

   assign force_upd = wr_ctrl && bus_wdata_i[CTRL_FORCE_BIT];
   assign uev       = wrap || force_upd;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q <= 1'b0;
         upd_o <= 1'b0;
      end else begin
         if (wr_ctrl) run_q <= bus_wdata_i[CTRL_RUN_BIT];
         upd_o <= uev;
      end
   end

   // ---------------- preload / active pairs ----------------
   logic [DIV_W-1:0] div_pre, div_act;
   logic [CNT_W-1:0] lim_pre, lim_act;
   logic [CNT_W-1:0] cmp_pre, cmp_act;
   logic [CNT_W-1:0] cnt_q;

   shtmr_shadow #(.W(DIV_W)) u_div_reg (
      .clk_i, .rst_ni, .wr_i(wr_div), .wdata_i(bus_wdata_i[DIV_W-1:0]),
      .load_i(uev), .pre_o(div_pre), .act_o(div_act));

   shtmr_shadow #(.W(CNT_W)) u_lim_reg (
      .clk_i, .rst_ni, .wr_i(wr_lim), .wdata_i(bus_wdata_i[CNT_W-1:0]),
      .load_i(uev), .pre_o(lim_pre), .act_o(lim_act));

   shtmr_shadow #(.W(CNT_W)) u_cmp_reg (
      .clk_i, .rst_ni, .wr_i(wr_cmp), .wdata_i(bus_wdata_i[CNT_W-1:0]),
      .load_i(uev), .pre_o(cmp_pre), .act_o(cmp_act));

   // ---------------- counting ----------------
   shtmr_divider #(.W(DIV_W)) u_divider (
      .clk_i, .rst_ni, .run_i(run_q), .clr_i(force_upd),
      .limit_i(div_act), .tick_o(tick));

   shtmr_counter #(.W(CNT_W)) u_counter (
      .clk_i, .rst_ni, .tick_i(tick), .clr_i(force_upd),
      .limit_i(lim_act), .cnt_o(cnt_q), .wrap_o(wrap));

   assign cmp_o = (cnt_q >= cmp_act);

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata_o = '0;
      if (in_map) begin
         case (idx)
            IDX_CTRL: bus_rdata_o[CTRL_RUN_BIT] = run_q;
            IDX_DIV:  bus_rdata_o[DIV_W-1:0]    = div_pre;
            IDX_LIM:  bus_rdata_o[CNT_W-1:0]    = lim_pre;
            IDX_CMP:  bus_rdata_o[CNT_W-1:0]    = cmp_pre;
            IDX_CNT:  bus_rdata_o[CNT_W-1:0]    = cnt_q;
            default:  bus_rdata_o               = '0;
         endcase
      end
   end

   // R3
   cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= lim_act);

   // R4
   upd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uev |=> upd_o);

   // R7
   force_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_upd |=> (cnt_q == '0 && upd_o));

   // R8
   halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q && !force_upd) |=> $stable(cnt_q));

endmodule

// File: tb/shadow_timer_test.sv
module shadow_timer_test;

   localparam int DW = 32;
   localparam int AW = 5;

   localparam logic [AW-1:0] A_CTRL = 5'h00;
   localparam logic [AW-1:0] A_DIV  = 5'h04;
   localparam logic [AW-1:0] A_LIM  = 5'h08;
   localparam logic [AW-1:0] A_CMP  = 5'h0C;
   localparam logic [AW-1:0] A_CNT  = 5'h10;
   localparam logic [AW-1:0] A_NONE = 5'h14;

   // Vectors: divider, limit, compare, edges run, expected count, pulses, cmp
   localparam int NV = 6;
   localparam int V_DIV[NV]   = '{0, 2, 3, 1, 4, 0};
   localparam int V_LIM[NV]   = '{9, 4, 7, 0, 3, 100};
   localparam int V_CMP[NV]   = '{5, 3, 6, 0, 3, 50};
   localparam int V_RUN[NV]   = '{25, 40, 30, 10, 24, 49};
   localparam int V_CNT[NV]   = '{5, 3, 7, 0, 0, 49};
   localparam int V_PULS[NV]  = '{3, 3, 1, 6, 2, 1};
   localparam int V_CMPO[NV]  = '{1, 1, 1, 1, 0, 0};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          upd, cmp;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   shadow_timer #(.DATA_W(DW), .CNT_W(16), .DIV_W(16), .ADDR_W(AW)) uut (
      .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .upd_o(upd), .cmp_o(cmp));

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input int d);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; wdata = '0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output int d);
      addr = a;
      #1;
      d = int'(rdata);
   endtask

   task automatic check_reg(input string req, input logic [AW-1:0] a, input int exp);
      int v;
      bus_read(a, v);
      check(req, v, exp);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int pulses;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      check_reg("R1 ctrl", A_CTRL, 0);
      check_reg("R1 div", A_DIV, 0);
      check_reg("R1 lim", A_LIM, 0);
      check_reg("R1 cmp", A_CMP, 0);
      check_reg("R1 cnt", A_CNT, 0);
      check("R1 upd_o", int'(upd), 0);
      check("R1 cmp_o", int'(cmp), 1);
      step(5);
      check_reg("R8 idle after reset", A_CNT, 0);

      // Vector table: R2 R3 R4 R9 R10
      for (int v = 0; v < NV; v++) begin
         bus_write(A_DIV, V_DIV[v]);
         bus_write(A_LIM, V_LIM[v]);
         bus_write(A_CMP, V_CMP[v]);
         check_reg("R10 div preload", A_DIV, V_DIV[v]);
         check_reg("R10 lim preload", A_LIM, V_LIM[v]);
         check_reg("R10 cmp preload", A_CMP, V_CMP[v]);
         bus_write(A_CTRL, 3);
         pulses = int'(upd);
         for (int k = 0; k < V_RUN[v]; k++) begin
            @(negedge clk);
            if (upd) pulses++;
         end
         check_reg("R2 R3 count", A_CNT, V_CNT[v]);
         check("R4 pulse count", pulses, V_PULS[v]);
         check("R9 cmp_o", int'(cmp), V_CMPO[v]);
      end

      // Directed: preload shadowing (R5), edge-coincident write (R6)
      bus_write(A_DIV, 0);
      bus_write(A_LIM, 9);
      bus_write(A_CMP, 4);
      bus_write(A_CTRL, 3);                 // edge F
      check_reg("R7 cleared", A_CNT, 0);
      step(2);
      bus_write(A_LIM, 20);                 // edge F+3
      check_reg("R10 preload readback", A_LIM, 20);
      check_reg("R5 cnt F+3", A_CNT, 3);
      bus_write(A_CMP, 8);                  // edge F+4
      check_reg("R5 cnt F+4", A_CNT, 4);
      check("R5 cmp still old", int'(cmp), 1);
      step(5);
      check_reg("R3 cnt at limit", A_CNT, 9);
      step(1);                              // F+10 rollover
      check_reg("R3 rollover", A_CNT, 0);
      check("R4 pulse on rollover", int'(upd), 1);
      check("R5 cmp new active", int'(cmp), 0);
      step(1);
      check("R4 single pulse", int'(upd), 0);
      step(14);                             // F+25
      check_reg("R5 new limit used", A_CNT, 15);
      step(5);                              // F+30
      bus_write(A_LIM, 5);                  // edge F+31, rollover edge
      check_reg("R6 rollover same edge", A_CNT, 0);
      check("R6 pulse", int'(upd), 1);
      step(6);                              // F+37
      check_reg("R6 old limit kept", A_CNT, 6);
      step(20);                             // F+57
      check_reg("R6 new limit later", A_CNT, 5);
      step(1);                              // F+58
      check_reg("R3 wrap at 5", A_CNT, 0);
      check("R4 pulse at 5", int'(upd), 1);

      // Disable (R8)
      bus_write(A_CTRL, 0);                 // last tick still taken
      check_reg("R8 ctrl reads 0", A_CTRL, 0);
      check_reg("R8 cnt at stop", A_CNT, 1);
      pulses = 0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (upd) pulses++;
      end
      check_reg("R8 hold", A_CNT, 1);
      check("R8 no pulse", pulses, 0);

      // Forced update while disabled (R7)
      bus_write(A_CTRL, 2);
      check_reg("R7 forced clear", A_CNT, 0);
      check("R7 forced pulse", int'(upd), 1);
      check_reg("R7 bit1 reads 0", A_CTRL, 0);
      step(1);
      check("R7 pulse ends", int'(upd), 0);
      check_reg("R7 stays idle", A_CNT, 0);

      // Read-only counter and unmapped space (R10)
      bus_write(A_CNT, 7);
      check_reg("R10 cnt write ignored", A_CNT, 0);
      bus_write(A_NONE, 9);
      check_reg("R10 unmapped reads 0", A_NONE, 0);
      bus_write(5'h05, 33);
      check_reg("R10 misaligned no write", A_DIV, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule